// File: doc/BRIEF.md
# Lane-Partitioned SIMD Minimum

This block takes two operand words, `x_i` and `y_i`, cut into `NS` equal sections of `SW` bits each. It returns their minimum one lane at a time. A runtime partition mask of `NS-1` bits sets where the lane boundaries fall. With no boundary set, the whole word is one lane and is compared as a single wide unsigned value. With every boundary set, each section is an independent lane. Any mix in between is also legal.

Inside a merged lane, the per-section compare results ripple from the least significant section towards the most significant one. The ripple stops at every boundary. The result reaching the top section of a lane is then spread back down to every section of that lane. That result selects `x` or `y` for the lane.

Results are registered. They appear one clock after the operands and mask are presented. A per-section less-than flag comes out next to the minimum word.

Top module: `simd_min_unit`

## Requirements
- R1: For every lane, `min_o` holds the lane's bits of `x_i` when x is unsigned-less-than y for that lane, and the lane's bits of `y_i` otherwise.
- R2: Section k occupies bits [k*SW +: SW], with section 0 least significant. `mask_i[k]=1` places a lane boundary between section k and section k+1, and `mask_i[k]=0` joins them. All 2^(NS-1) mask values are legal.
- R3: A lane's output bits and flags depend only on the operand bits inside that lane. Changing data in another lane does not change them.
- R4: A merged lane compares as one wide unsigned value. A more significant section decides unless its x and y bits are equal, and only then does the next lower section decide.
- R5: When a lane's x equals its y, the lane output equals that common value and its less-than flags are 0.
- R6: `lt_o[k]` is 1 exactly when the lane holding section k has x < y. All sections of one lane carry the same flag value.
- R7: Outputs are registered. The result for inputs sampled at a rising clock edge is visible right after that edge and holds until the next edge.
- R8: While `rst` is high at a rising edge, `min_o` and `lt_o` are cleared to zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | NS*SW | First operand word |
| y_i | input | NS*SW | Second operand word |
| mask_i | input | NS-1 | Lane boundary mask, bit k set splits sections k and k+1 |
| min_o | output | NS*SW | Registered lane-wise minimum |
| lt_o | output | NS | Registered per-section lane less-than flag |

## Verification
The hardest case to reach is a merged lane whose upper sections hold equal bytes, so that the decision has to ripple down from a low section through several equal ones. Uniform random data almost never makes two bytes equal. The stimulus therefore builds such operands on purpose. It copies x into y and then nudges one low section up or down, under every mask value. It also feeds fully equal operands for every mask and pairs where the upper section and the lower sections point in opposite directions.

// File: rtl/simd_min_pkg.sv
package simd_min_pkg;

  // Result of comparing one section of x against the same section of y.
  typedef struct packed {
    logic lt;
    logic eq;
  } sec_cmp_t;

endpackage

// File: rtl/simd_sec_cmp.sv
module simd_sec_cmp
  import simd_min_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  output sec_cmp_t      res_o
);

  always_comb begin
    res_o.lt = (a_i < b_i);
    res_o.eq = (a_i == b_i);
  end

endmodule

// File: rtl/simd_lane_chain.sv
module simd_lane_chain
  import simd_min_pkg::*;
#(
  parameter int NS = 4,
  localparam int MW = NS - 1
) (
  input  sec_cmp_t [NS-1:0] cmp_i,
  input  logic [MW-1:0]     mask_i,
  output logic [NS-1:0]     sel_o
);

  // up[k]: x<y over sections from the lane base up to k (ripple upward)
  logic [NS-1:0] up;
  logic [NS-1:0] cin;

  genvar k;
  generate
    for (k = 0; k < NS; k++) begin : g_up
      if (k == 0) begin : g_base
        assign cin[k] = 1'b0;
      end else begin : g_link
        assign cin[k] = mask_i[k-1] ? 1'b0 : up[k-1];
      end
      assign up[k] = cmp_i[k].lt | (cmp_i[k].eq & cin[k]);
    end

    // broadcast the decision at a lane's top section down to its members
    for (k = NS - 1; k >= 0; k--) begin : g_dn
      if (k == NS - 1) begin : g_top
        assign sel_o[k] = up[k];
      end else begin : g_mid
        assign sel_o[k] = mask_i[k] ? up[k] : sel_o[k+1];
      end
    end
  endgenerate

endmodule

// File: rtl/simd_min_unit.sv
module simd_min_unit
  import simd_min_pkg::*;
#(
  parameter int NS = 4,
  parameter int SW = 8,
  localparam int W  = NS * SW,
  localparam int MW = NS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  input  logic [MW-1:0] mask_i,
  output logic [W-1:0]  min_o,
  output logic [NS-1:0] lt_o
);

  sec_cmp_t [NS-1:0] cmp;
  logic [NS-1:0]     sel;
  logic [W-1:0]      pick;

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_sec
      simd_sec_cmp #(.SW(SW)) u_cmp (
        .a_i   (x_i[s*SW +: SW]),
        .b_i   (y_i[s*SW +: SW]),
        .res_o (cmp[s])
      );
      assign pick[s*SW +: SW] = sel[s] ? x_i[s*SW +: SW] : y_i[s*SW +: SW];
    end
  endgenerate

  simd_lane_chain #(.NS(NS)) u_chain (
    .cmp_i  (cmp),
    .mask_i (mask_i),
    .sel_o  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      min_o <= '0;
      lt_o  <= '0;
    end else begin
      min_o <= pick;
      lt_o  <= sel;
    end
  end

  // R1 R4: with no boundary the whole word is one unsigned compare
  wide_min_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_i) == '0) |->
      (min_o == (($past(x_i) < $past(y_i)) ? $past(x_i) : $past(y_i))));

  generate
    for (s = 0; s < NS; s++) begin : g_chk
      // R3: all boundaries set, each section is its own lane
      split_min_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mask_i) == '1) |->
          (min_o[s*SW +: SW] == (($past(x_i[s*SW +: SW]) < $past(y_i[s*SW +: SW]))
                                 ? $past(x_i[s*SW +: SW]) : $past(y_i[s*SW +: SW]))));
      // R1: every output section comes from one of the operands
      from_operand_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
          (min_o[s*SW +: SW] == $past(x_i[s*SW +: SW]) ||
           min_o[s*SW +: SW] == $past(y_i[s*SW +: SW])));
      if (s < NS - 1) begin : g_join
        // R6: sections joined by a clear mask bit share one flag
        flag_join_chk: assert property (@(posedge clk) disable iff (rst)
          (!$past(rst) && !$past(mask_i[s])) |-> (lt_o[s] == lt_o[s+1]));
      end
    end
  endgenerate

endmodule

// File: tb/sim_simd_min_unit.sv
module sim_simd_min_unit;

  localparam int NS = 4;
  localparam int SW = 8;
  localparam int W  = NS * SW;
  localparam int MW = NS - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  x_i = '0;
  logic [W-1:0]  y_i = '0;
  logic [MW-1:0] mask_i = '0;
  logic [W-1:0]  min_o;
  logic [NS-1:0] lt_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0]  x;
    logic [W-1:0]  y;
    logic [MW-1:0] m;
    logic [W-1:0]  emin;
    logic [NS-1:0] elt;
    string         tag;
  } item_t;

  item_t sb[$];

  simd_min_unit #(.NS(NS), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i), .mask_i(mask_i),
    .min_o(min_o), .lt_o(lt_o)
  );

  always #5 clk = ~clk;

  // Per-lane reference built from the lane rules.
  function automatic void ref_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [MW-1:0] m,
                                   output logic [W-1:0] mn, output logic [NS-1:0] lt);
    int lo;
    lo = 0;
    mn = '0;
    lt = '0;
    for (int s = 0; s < NS; s++) begin
      if (s == NS - 1 || m[s]) begin
        logic [W-1:0] av;
        logic [W-1:0] bv;
        logic l;
        av = '0;
        bv = '0;
        for (int k = lo * SW; k < (s + 1) * SW; k++) begin
          av[k] = a[k];
          bv[k] = b[k];
        end
        l = (av < bv);
        for (int k = lo * SW; k < (s + 1) * SW; k++) mn[k] = l ? a[k] : b[k];
        for (int t = lo; t <= s; t++) lt[t] = l;
        lo = s + 1;
      end
    end
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [MW-1:0] m, input string tag);
    item_t it;
    @(negedge clk);
    x_i = a;
    y_i = b;
    mask_i = m;
    it.x = a;
    it.y = b;
    it.m = m;
    it.tag = tag;
    ref_calc(a, b, m, it.emin, it.elt);
    sb.push_back(it);
  endtask

  // Monitor: results show just after the edge that captured the item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (min_o !== it.emin || lt_o !== it.elt) begin
          bad++;
          $display("FAIL %s: mask=%b x=%h y=%h min actual=%h expected=%h lt actual=%b expected=%b",
                   it.tag, it.m, it.x, it.y, min_o, it.emin, lt_o, it.elt);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > 50000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] b;
    // R8: reset clears outputs while inputs are busy
    x_i = 32'h0000_0001;
    y_i = 32'hFFFF_FFFF;
    mask_i = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (min_o !== '0 || lt_o !== '0) begin
      bad++;
      $display("FAIL R8: min actual=%h expected=0 lt actual=%b expected=0", min_o, lt_o);
    end
    rst = 1'b0;

    // R7: first result lands one edge after capture
    send(32'h0102_0304, 32'h0102_0305, 3'b000, "R7");
    send(32'hFF00_00FF, 32'h00FF_FF00, 3'b111, "R7");

    // R4: upper section decides; equal upper lets lower decide
    send(32'h1300_0000, 32'h12FF_FFFF, 3'b000, "R4");
    send(32'h1234_5678, 32'h1234_5679, 3'b000, "R4");
    send(32'h55AA_1020, 32'h55A9_1021, 3'b010, "R4");
    send(32'h0000_80FF, 32'h0000_7F00, 3'b101, "R4");

    // R3: lane 0 fixed, neighbours vary
    for (int i = 0; i < 6; i++) begin
      a = {$urandom()} ; a[7:0] = 8'h10;
      b = {$urandom()} ; b[7:0] = 8'h20;
      send(a, b, 3'b001, "R3");
    end

    // R2 R1 R6: every mask, random data
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 30; i++) begin
        a = $urandom();
        b = $urandom();
        send(a, b, m[MW-1:0], "R1");
      end
    end

    // R5: equal operands under every mask
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 3; i++) begin
        a = $urandom();
        send(a, a, m[MW-1:0], "R5");
      end
    end

    // R4 R6: equal copies nudged in one low section
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < NS; s++) begin
        a = $urandom();
        b = a;
        b[s*SW +: SW] = a[s*SW +: SW] + 8'd1;
        send(a, b, m[MW-1:0], "R6");
        send(b, a, m[MW-1:0], "R2");
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule